// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a computer-operating-properly watchdog. It counts enabled clock cycles through a 4-bit prescaler stage followed by a main counter. If software does not service it before the selected period expires, it raises a one-cycle reset request. A rate-select input chooses between a long period of 2^LONG_BITS − 16 cycles and a short period of 2^SHORT_BITS − 16 cycles. With the defaults these are 262,128 and 8,176 cycles.

The block watches a processor-style address bus. It does not own a register of its own. Software services it by writing anything to the top address of memory. A read of that same address returns the low byte of the reset vector, which is supplied as a parameter. When the processor fetches the reset vector, the prescaler is cleared. A disable input holds the block idle, and so does a monitor-mode input that signals a high voltage on a control pin. A stop input freezes the count. Wait mode has no input of its own, so the count keeps running during wait.

Top module: `cop_watchdog`

## Requirements
- R1: With rateSel = 0 and no other stimulus after reset, rstReq is high only in the cycle after the (2^SHORT_BITS − 16)-th clock edge.
- R2: With rateSel = 1 and no other stimulus after reset, rstReq is high only in the cycle after the (2^LONG_BITS − 16)-th clock edge.
- R3: rstReq is a single-cycle pulse. A timeout returns both stages to zero, so the next pulse follows exactly one further period.
- R4: The clock edge that samples busWr = 1 with busAddr = all ones clears the main stage only. The prescaler keeps its count, so the next timeout lands at edge period + e − (e mod 16), where e is the write edge.
- R5: A write to any other address has no effect on timing.
- R6: The clock edge that samples vecFetch = 1 with busAddr equal to either of the two top addresses (all ones, or all ones with bit 0 cleared) clears the prescaler only.
- R7: While copDis = 1, both stages are held at zero and rstReq stays low. Counting restarts from zero when copDis falls.
- R8: monMode = 1 has the same effect as copDis = 1.
- R9: While stopMode = 1, both stages hold their values. The timeout is then delayed by the number of stopped edges.
- R10: rdData equals VEC_LO when busRd = 1 and busAddr is all ones. Otherwise rdData is zero. The bus path is combinational.
- R11: An active-low rstN clears both stages and rstReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| copDis | input | 1 | Configuration disable bit |
| monMode | input | 1 | Monitor-mode indication, forces the watchdog off |
| stopMode | input | 1 | Stop indication, freezes the count |
| rateSel | input | 1 | 1 selects the long period, 0 selects the short period |
| busAddr | input | ADDR_W | Bus address |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe |
| vecFetch | input | 1 | Marks a vector fetch cycle |
| rdData | output | 8 | Read data, the reset vector low byte on a hit |
| rstReq | output | 1 | Single-cycle reset request |

## Verification
Each run uses a small configuration with periods of 240 and 48 cycles. On every edge, the bench compares rstReq against an edge number it computes arithmetically. Free-running sweeps at both rates check the period and the return to zero after a timeout. A service write placed on and off a 16-edge boundary shows that only the main stage is cleared. A vector fetch shifts the timeout by the prescaler residue alone, which tells the two clear paths apart. Further sweeps hold disable, monitor mode and stop for long windows: the first two must restart counting from zero, while stop must resume from the held value. A write to a neighbouring address must leave the timing unchanged.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef struct packed {
    logic step;     // advance the prescaler this cycle
    logic clrPre;   // clear the prescaler stage
    logic clrMain;  // clear the main stage
    logic fire;     // timeout reached, issue the pulse
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter logic [ADDR_W-1:0] VEC_HI_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0}
) (
  input  logic              copDis,
  input  logic              monMode,
  input  logic              stopMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              vecFetch,
  input  logic              atLimit,
  output wdgStrobe_t        st
);
  logic active;
  logic svcHit;
  logic vecHit;

  always_comb begin
    active = !copDis && !monMode;
    svcHit = busWr && (busAddr == SVC_ADDR);
    vecHit = vecFetch && ((busAddr == SVC_ADDR) || (busAddr == VEC_HI_ADDR));
    st.step    = active && !stopMode;
    st.clrMain = !active || svcHit;
    st.clrPre  = !active || vecHit;
    st.fire    = st.step && atLimit && !st.clrMain && !st.clrPre;
  end
endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int PRE_BITS   = 4,
  parameter int LONG_BITS  = 18,
  parameter int SHORT_BITS = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateSel,
  input  wdgStrobe_t st,
  output logic       atLimit,
  output logic       rstReq
);
  localparam int MAIN_W = LONG_BITS - PRE_BITS;
  localparam int SHORT_MAIN_W = SHORT_BITS - PRE_BITS;
  localparam logic [MAIN_W-1:0] LIMIT_L = MAIN_W'((64'd1 << MAIN_W) - 64'd2);
  localparam logic [MAIN_W-1:0] LIMIT_S = MAIN_W'((64'd1 << SHORT_MAIN_W) - 64'd2);

  logic [PRE_BITS-1:0] preCnt;
  logic [MAIN_W-1:0]   mainCnt;
  logic                preFull;

  always_comb begin
    preFull = &preCnt;
    atLimit = preFull && (mainCnt == (rateSel ? LIMIT_L : LIMIT_S));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      mainCnt <= '0;
      rstReq  <= 1'b0;
    end else if (st.fire) begin
      preCnt  <= '0;
      mainCnt <= '0;
      rstReq  <= 1'b1;
    end else begin
      rstReq <= 1'b0;
      if (st.clrPre)     preCnt <= '0;
      else if (st.step)  preCnt <= preCnt + 1'b1;
      if (st.clrMain)               mainCnt <= '0;
      else if (st.step && preFull)  mainCnt <= mainCnt + 1'b1;
    end
  end

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  // R3
  fire_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (preCnt == '0) && (mainCnt == '0));
  // R4
  main_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.clrMain |=> (mainCnt == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.step && !st.clrPre && !st.clrMain) |=> $stable(preCnt) && $stable(mainCnt));
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PRE_BITS   = 4,
  parameter int LONG_BITS  = 18,
  parameter int SHORT_BITS = 13,
  parameter logic [7:0] VEC_LO = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              copDis,
  input  logic              monMode,
  input  logic              stopMode,
  input  logic              rateSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              vecFetch,
  output logic [7:0]        rdData,
  output logic              rstReq
);
  localparam logic [ADDR_W-1:0] SVC_ADDR = '1;

  wdgStrobe_t st;
  logic atLimit;

  wdg_ctrl #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_ctrl (
    .copDis(copDis), .monMode(monMode), .stopMode(stopMode),
    .busAddr(busAddr), .busWr(busWr), .vecFetch(vecFetch),
    .atLimit(atLimit), .st(st)
  );

  wdg_datapath #(.PRE_BITS(PRE_BITS), .LONG_BITS(LONG_BITS), .SHORT_BITS(SHORT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .st(st),
    .atLimit(atLimit), .rstReq(rstReq)
  );

  assign rdData = (busRd && (busAddr == SVC_ADDR)) ? VEC_LO : 8'h00;

  // R7 R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (copDis || monMode) |=> !rstReq);
  // R10
  read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busAddr == SVC_ADDR)) |-> (rdData == VEC_LO));
endmodule

// File: tb/cop_watchdog_bench.sv
module cop_watchdog_bench;
  localparam int PB = 4, LB = 8, SB = 6;
  localparam int TL = (1 << LB) - 16;
  localparam int TS = (1 << SB) - 16;
  localparam logic [7:0] VLO = 8'hC3;

  logic clk = 1'b0, rstN = 1'b0;
  logic copDis = 0, monMode = 0, stopMode = 0, rateSel = 0;
  logic [15:0] busAddr = 16'h0000;
  logic busWr = 0, busRd = 0, vecFetch = 0;
  logic [7:0] rdData;
  logic rstReq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cop_watchdog #(.ADDR_W(16), .PRE_BITS(PB), .LONG_BITS(LB), .SHORT_BITS(SB), .VEC_LO(VLO)) u_cop_watchdog (
    .clk(clk), .rstN(rstN), .copDis(copDis), .monMode(monMode), .stopMode(stopMode),
    .rateSel(rateSel), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .vecFetch(vecFetch), .rdData(rdData), .rstReq(rstReq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic resetDut();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  // kind: 0 none, 1 write svc, 2 write other, 3 fetch FFFE, 4 disable,
  //       5 monitor, 6 stop, 7 fetch FFFF
  task automatic sweep(input int kind, input bit rate, input int evEdge, input int evLen,
                       input int fire1, input int fire2, input int total, input string req);
    int bad = 0, badK = 0, badV = 0;
    rateSel = rate;
    resetDut();
    for (int k = 1; k <= total; k++) begin
      bit on = (k >= evEdge) && (k < evEdge + evLen);
      busWr = on && (kind == 1 || kind == 2);
      vecFetch = on && (kind == 3 || kind == 7);
      busAddr = (kind == 2 || kind == 3) ? 16'hFFFE : 16'hFFFF;
      copDis = on && kind == 4;
      monMode = on && kind == 5;
      stopMode = on && kind == 6;
      @(posedge clk);
      #1;
      if (rstReq !== ((k == fire1) || (k == fire2)) && bad == 0) begin
        bad = 1; badK = k; badV = rstReq;
      end
    end
    busWr = 0; vecFetch = 0; copDis = 0; monMode = 0; stopMode = 0; busAddr = 16'h0000;
    if (bad) $display("  mismatch at edge %0d", badK);
    chk(bad == 0, req, badV, (badK == fire1 || badK == fire2) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0;
    #1;
    // R11 reset state
    chk(rstReq == 0, "R11", rstReq, 0);
    chk(rdData == 0, "R11", rdData, 0);
    sweep(0, 0, 0, 0, TS, 0, TS + 5, "R1");
    sweep(0, 1, 0, 0, TL, 0, TL + 5, "R2");
    sweep(0, 0, 0, 0, TS, 2 * TS, 2 * TS + 3, "R3");
    sweep(0, 1, 0, 0, TL, 2 * TL, 2 * TL + 3, "R3");
    sweep(1, 1, 32, 1, TL + 32 - (32 % 16), 0, TL + 40, "R4");
    sweep(1, 1, 37, 1, TL + 37 - (37 % 16), 0, TL + 40, "R4");
    sweep(1, 0, 21, 1, TS + 21 - (21 % 16), 0, TS + 30, "R4");
    sweep(2, 1, 37, 1, TL, 0, TL + 10, "R5");
    sweep(3, 1, 37, 1, TL + (37 % 16), 0, TL + 10, "R6");
    sweep(7, 0, 20, 1, TS + (20 % 16), 0, TS + 10, "R6");
    sweep(4, 0, 1, 3 * TS, 3 * TS + TS, 0, 4 * TS + 5, "R7");
    sweep(4, 1, 50, 300, 349 + TL, 0, 349 + TL + 5, "R7");
    sweep(5, 0, 1, 3 * TS, 3 * TS + TS, 0, 4 * TS + 5, "R8");
    sweep(6, 1, 11, 100, TL + 100, 0, TL + 105, "R9");
    sweep(6, 0, 5, 60, TS + 60, 0, TS + 65, "R9");
    // R10 read path
    busRd = 1; busAddr = 16'hFFFF; #1;
    chk(rdData == VLO, "R10", rdData, VLO);
    busAddr = 16'hFFFE; #1;
    chk(rdData == 0, "R10", rdData, 0);
    busRd = 0; busAddr = 16'hFFFF; #1;
    chk(rdData == 0, "R10", rdData, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule